// File: doc/BRIEF.md
# MIDI Port Status and Interrupt Unit

This block builds the status byte and the single interrupt request of a MIDI serial port. The port runs either in a pass-through mode, where receive and transmit each hold one byte, or in a UART mode, where both directions use FIFOs. The pass-through mode can also enable its receive FIFO. The serial engine, the FIFO storage and the host bus decode sit outside this block. They supply the mode, the FIFO-enable bit, the fill levels of both directions, and one-cycle strobes for a received byte, a host read of receive data, a host write of transmit data and a host read of the status byte.

The unit keeps a sticky overrun flag. It tracks the receive threshold and a receive idle timeout of about four byte times. In UART mode it applies hysteresis to the transmit-empty request. It also holds the two interrupt-enable bits of the control register. The interrupt line is a registered OR of the enabled receive and transmit conditions.

Top module: `midi_stat_irq`

## Requirements
- R1: Status bit 4 equals `uart_mode` (1 = UART, 0 = pass-through). Bits 7, 6, 1 and 0 always read 0.
- R2: "FIFO mode" means `uart_mode | rx_fifo_en`. In FIFO mode, status bit 5 is 1 exactly when `rx_level == DEPTH`, and bit 2 is 1 exactly when `tx_level == 0`. Outside FIFO mode both bits read 0.
- R3: The receive store is full when `rx_level >= 1` outside FIFO mode, or when `rx_level >= DEPTH` in FIFO mode. A `rx_byte_in` strobe while the store is full sets the overrun flag (status bit 3) at the next clock edge. This applies in both modes. A strobe while the store is not full leaves the flag unchanged.
- R4: A `stat_rd` strobe clears the overrun flag at the next edge. If an overrun event occurs in the same cycle, the flag stays set.
- R5: Outside FIFO mode, the receive condition is `rx_level != 0`.
- R6: In FIFO mode, the receive condition holds while `rx_level >= RX_THRESH` (default 8).
- R7: In FIFO mode with `0 < rx_level < RX_THRESH`, the receive condition also holds once TIMEOUT_CYC consecutive cycles have passed with no `rx_byte_in` and no `rx_read`. It drops in the first cycle that has either strobe, and restarts its count from there. An empty FIFO keeps the count at zero.
- R8: In pass-through mode, the transmit condition is `tx_level == 0`.
- R9: In UART mode, the transmit condition sets when `tx_level == 0`. It stays set until `tx_level >= TX_RELEASE` (default 3).
- R10: After reset, `rx_ie` = 1 and `tx_ie` = 0. A `ctl_wr` strobe loads `rx_ie` from `ctl_wdata[3]` and `tx_ie` from `ctl_wdata[1]` at the next edge.
- R11: At each edge, `irq` takes the value `(rx_ie & receive condition) | (tx_ie & transmit condition)` evaluated in the cycle before that edge. `irq` is 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_mode | input | 1 | 1 = UART mode, 0 = pass-through |
| rx_fifo_en | input | 1 | Receive FIFO enabled in pass-through mode |
| rx_level | input | LVL_W | Unread bytes in the receive buffer or FIFO |
| tx_level | input | LVL_W | Bytes waiting in the transmit buffer or FIFO |
| rx_byte_in | input | 1 | Serial engine delivered a byte this cycle |
| rx_read | input | 1 | Host read receive data this cycle |
| tx_write | input | 1 | Host wrote transmit data this cycle (the level carries its effect) |
| stat_rd | input | 1 | Host read the status byte this cycle |
| ctl_wr | input | 1 | Host write of the control register |
| ctl_wdata | input | 8 | Control write data |
| status | output | 8 | Status byte |
| rx_ie | output | 1 | Receive interrupt enable |
| tx_ie | output | 1 | Transmit interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt and status logic is first driven with long random runs in each of the three mode combinations. Each run uses fill levels biased toward empty, full and the threshold, so the FIFO-mode rules are told apart from the single-byte rules on the same stimulus. Quiet stretches with steady non-empty levels let the idle timeout expire, which separates it from the threshold path. Directed sequences then cover the same-cycle status read and overrun, overrun in the single-byte store at a level of one, the transmit level stepping 0-1-2-3-2 to expose the hysteresis, and control writes that mask each source separately.

// File: rtl/midi_si_pkg.sv
package midi_si_pkg;
   // status byte fields (host software decodes these positions)
   localparam int ST_RXFULL  = 5;
   localparam int ST_MODE    = 4;
   localparam int ST_OVR     = 3;
   localparam int ST_TXEMPTY = 2;
   // control register enable fields
   localparam int CTL_RXIE   = 3;
   localparam int CTL_TXIE   = 1;

   typedef struct packed {
      logic rx_ie;
      logic tx_ie;
   } irq_en_t;
endpackage

// File: rtl/midi_si_ovr.sv
module midi_si_ovr #(
   parameter int DEPTH = 16,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_mode,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             rx_byte_in,
   input  logic             stat_rd,
   output logic             ovr_q
);
   logic [LVL_W-1:0] cap;
   logic             store_full;
   logic             lost;

   assign cap        = fifo_mode ? LVL_W'(DEPTH) : LVL_W'(1);
   assign store_full = (rx_level >= cap);
   assign lost       = rx_byte_in & store_full;

   always_ff @(posedge clk) begin
      if (!rst_n)       ovr_q <= 1'b0;
      else if (lost)    ovr_q <= 1'b1;
      else if (stat_rd) ovr_q <= 1'b0;
   end

   // R3: a byte into a full store is flagged
   a_r3_flag_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_byte_in && fifo_mode && rx_level == LVL_W'(DEPTH)) |=> ovr_q);
   // R4: a plain status read clears, a coincident overrun wins
   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !rx_byte_in) |=> !ovr_q);
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_q && !rx_byte_in) |=> !ovr_q);
endmodule

// File: rtl/midi_si_rxirq.sv
module midi_si_rxirq #(
   parameter int DEPTH       = 16,
   parameter int RX_THRESH   = 8,
   parameter int TIMEOUT_CYC = 320000,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_mode,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             rx_byte_in,
   input  logic             rx_read,
   output logic             rx_cond
);
   logic quiet;
   logic to_q;
   logic thr_hit;

   assign quiet   = fifo_mode & (rx_level != '0) & ~rx_byte_in & ~rx_read;
   assign thr_hit = (rx_level >= LVL_W'(RX_THRESH));

   generate
      if (TIMEOUT_CYC == 0) begin : g_no_timer
         assign to_q = 1'b0;
      end else begin : g_timer
         localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
         logic [CNT_W-1:0] idle_cnt;
         logic             expired_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !quiet) begin
               idle_cnt  <= '0;
               expired_q <= 1'b0;
            end else if (idle_cnt == CNT_W'(TIMEOUT_CYC - 1)) begin
               expired_q <= 1'b1;
            end else begin
               idle_cnt <= idle_cnt + 1'b1;
            end
         end
         assign to_q = expired_q;
         // R7: any receive or read activity restarts the idle window
         a_r7_activity_restarts: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_byte_in || rx_read) |=> (!expired_q && idle_cnt == '0));
      end
   endgenerate

   always_comb begin
      if (fifo_mode) rx_cond = thr_hit | (to_q & quiet);
      else           rx_cond = (rx_level != '0);
   end

   // R6: at or above threshold in FIFO mode the condition is present
   a_r6_threshold: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_mode && rx_level >= LVL_W'(RX_THRESH)) |-> rx_cond);
   // R5: empty single-byte buffer never requests
   a_r5_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> !rx_cond);
endmodule

// File: rtl/midi_si_txirq.sv
module midi_si_txirq #(
   parameter int DEPTH      = 16,
   parameter int TX_RELEASE = 3,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uart_mode,
   input  logic [LVL_W-1:0] tx_level,
   output logic             tx_cond
);
   logic hyst_next;
   logic hold_q;

   assign hyst_next = (tx_level == '0) |
                      (hold_q & (tx_level < LVL_W'(TX_RELEASE)));

   always_ff @(posedge clk) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= hyst_next;
   end

   assign tx_cond = uart_mode ? hyst_next : (tx_level == '0);

   // R9: once set, the UART request survives partial refills
   a_r9_hysteresis: assert property (@(posedge clk) disable iff (!rst_n)
      (uart_mode && tx_level == '0) |=>
      (tx_level < LVL_W'(TX_RELEASE)) |-> tx_cond);
   // R9: at or above the release level the request is gone
   a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level >= LVL_W'(TX_RELEASE)) |-> !tx_cond);
endmodule

// File: rtl/midi_stat_irq.sv
module midi_stat_irq
   import midi_si_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int RX_THRESH   = 8,
   parameter int TX_RELEASE  = 3,
   parameter int TIMEOUT_CYC = 320000,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             uart_mode,
   input  logic             rx_fifo_en,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             rx_byte_in,
   input  logic             rx_read,
   input  logic             tx_write,
   input  logic             stat_rd,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_wdata,
   output logic [7:0]       status,
   output logic             rx_ie,
   output logic             tx_ie,
   output logic             irq
);
   generate
      if (DEPTH < 2)
         $error("DEPTH must be at least 2");
      if (RX_THRESH < 1 || RX_THRESH > DEPTH)
         $error("RX_THRESH must lie in 1..DEPTH");
      if (TX_RELEASE < 1 || TX_RELEASE > DEPTH)
         $error("TX_RELEASE must lie in 1..DEPTH");
      if (TIMEOUT_CYC == 1)
         $error("TIMEOUT_CYC must be 0 (off) or at least 2");
   endgenerate

   logic    fifo_mode;
   logic    ovr_q;
   logic    rx_cond;
   logic    tx_cond;
   irq_en_t en_q;
   logic    unused_ok;

   assign fifo_mode = uart_mode | rx_fifo_en;
   assign unused_ok = tx_write;   // transmit writes act through tx_level

   midi_si_ovr #(.DEPTH(DEPTH)) ovr_i (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_level(rx_level),
      .rx_byte_in(rx_byte_in), .stat_rd(stat_rd), .ovr_q(ovr_q));

   midi_si_rxirq #(.DEPTH(DEPTH), .RX_THRESH(RX_THRESH),
                   .TIMEOUT_CYC(TIMEOUT_CYC)) rx_i (
      .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_level(rx_level),
      .rx_byte_in(rx_byte_in), .rx_read(rx_read), .rx_cond(rx_cond));

   midi_si_txirq #(.DEPTH(DEPTH), .TX_RELEASE(TX_RELEASE)) tx_i (
      .clk(clk), .rst_n(rst_n), .uart_mode(uart_mode), .tx_level(tx_level),
      .tx_cond(tx_cond));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q.rx_ie <= 1'b1;
         en_q.tx_ie <= 1'b0;
      end else if (ctl_wr) begin
         en_q.rx_ie <= ctl_wdata[CTL_RXIE];
         en_q.tx_ie <= ctl_wdata[CTL_TXIE];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (en_q.rx_ie & rx_cond) | (en_q.tx_ie & tx_cond);
   end

   always_comb begin
      status              = 8'h00;
      status[ST_RXFULL]   = fifo_mode & (rx_level == LVL_W'(DEPTH));
      status[ST_MODE]     = uart_mode;
      status[ST_OVR]      = ovr_q;
      status[ST_TXEMPTY]  = fifo_mode & (tx_level == '0);
   end

   assign rx_ie = en_q.rx_ie;
   assign tx_ie = en_q.tx_ie;

   // R11: with both sources masked the line falls
   a_r11_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q.rx_ie && !en_q.tx_ie) |=> !irq);
   // R10: control write lands in the enables
   a_r10_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> (rx_ie == $past(ctl_wdata[CTL_RXIE]) &&
                  tx_ie == $past(ctl_wdata[CTL_TXIE])));
   // R2: FIFO status flags stay low outside FIFO mode
   a_r2_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_mode |-> (!status[ST_RXFULL] && !status[ST_TXEMPTY]));
endmodule

// File: tb/midi_stat_irq_tb.sv
module midi_stat_irq_tb_top;
   localparam int DEPTH = 16;
   localparam int THR   = 8;
   localparam int REL   = 3;
   localparam int TO    = 24;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       uart_mode, rx_fifo_en, rx_byte_in, rx_read, tx_write, stat_rd, ctl_wr;
   logic [4:0] rx_level, tx_level;
   logic [7:0] ctl_wdata, status;
   logic       rx_ie, tx_ie, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model state
   bit m_ovr, m_hold, m_rxie, m_txie, m_irq;
   int m_quiet;

   always #2 clk = ~clk;

   midi_stat_irq #(.DEPTH(DEPTH), .RX_THRESH(THR), .TX_RELEASE(REL),
                   .TIMEOUT_CYC(TO)) dut_i (
      .clk(clk), .rst_n(rst_n), .uart_mode(uart_mode), .rx_fifo_en(rx_fifo_en),
      .rx_level(rx_level), .tx_level(tx_level), .rx_byte_in(rx_byte_in),
      .rx_read(rx_read), .tx_write(tx_write), .stat_rd(stat_rd),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .status(status),
      .rx_ie(rx_ie), .tx_ie(tx_ie), .irq(irq));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit [7:0] exp_status(bit um, bit fe, int rl, int tl, bit ovr);
      bit fm = um | fe;
      return {2'b00, fm && rl == DEPTH, um, ovr, fm && tl == 0, 2'b00};
   endfunction

   function automatic bit exp_rx(bit um, bit fe, int rl, bit rb, bit rr, int q);
      bit fm = um | fe;
      bit quiet = fm && rl != 0 && !rb && !rr;
      if (!fm) return rl != 0;            // R5
      return (rl >= THR) || (quiet && q >= TO);  // R6, R7
   endfunction

   function automatic bit exp_tx(bit um, int tl, bit hold);
      bit hy = (tl == 0) || (hold && tl < REL);
      return um ? hy : (tl == 0);          // R9, R8
   endfunction

   // called at a negedge: drive, check status, advance model, wait, check regs
   task automatic step(bit um, bit fe, int rl, int tl, bit rb, bit rr, bit tw,
                       bit sr, bit cw, bit [7:0] cd);
      bit fm, full, rxc, txc;
      uart_mode = um; rx_fifo_en = fe; rx_level = 5'(rl); tx_level = 5'(tl);
      rx_byte_in = rb; rx_read = rr; tx_write = tw; stat_rd = sr;
      ctl_wr = cw; ctl_wdata = cd;
      #1;
      chk("R1 mode/reserved bits", int'(status & 8'hD3), int'(exp_status(um, fe, rl, tl, m_ovr) & 8'hD3));
      chk("R2 fifo full/empty bits", int'(status & 8'h24), int'(exp_status(um, fe, rl, tl, m_ovr) & 8'h24));
      chk("R3 overrun bit", int'(status[3]), int'(m_ovr));
      fm   = um | fe;
      full = fm ? (rl >= DEPTH) : (rl >= 1);
      rxc  = exp_rx(um, fe, rl, rb, rr, m_quiet);
      txc  = exp_tx(um, tl, m_hold);
      m_irq  = (m_rxie & rxc) | (m_txie & txc);
      m_hold = (tl == 0) || (m_hold && tl < REL);
      if (fm && rl != 0 && !rb && !rr) m_quiet = (m_quiet < TO) ? m_quiet + 1 : TO;
      else m_quiet = 0;
      if (rb && full) m_ovr = 1'b1;        // R3, R4
      else if (sr)    m_ovr = 1'b0;
      if (cw) begin m_rxie = cd[3]; m_txie = cd[1]; end
      @(posedge clk);
      @(negedge clk);
      chk("R11 irq", int'(irq), int'(m_irq));
      chk("R10 enables", int'({rx_ie, tx_ie}), int'({m_rxie, m_txie}));
   endtask

   task automatic idle(bit um, bit fe, int rl, int tl, int n);
      for (int i = 0; i < n; i++) step(um, fe, rl, tl, 0, 0, 0, 0, 0, 8'h00);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int rl, tl;
      void'($urandom(32'd7301));
      rst_n = 1'b0;
      uart_mode = 0; rx_fifo_en = 0; rx_level = 0; tx_level = 0;
      rx_byte_in = 0; rx_read = 0; tx_write = 0; stat_rd = 0; ctl_wr = 0; ctl_wdata = 0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // reset state: R10, R11, R1
      chk("R10 reset rx_ie", int'(rx_ie), 1);
      chk("R10 reset tx_ie", int'(tx_ie), 0);
      chk("R11 reset irq", int'(irq), 0);
      chk("R1 reset status", int'(status), 0);
      m_ovr = 0; m_hold = 0; m_rxie = 1; m_txie = 0; m_irq = 0; m_quiet = 0;

      // R3: single byte store full at level 1, empty store takes a byte
      step(0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
      chk("R3 no overrun when empty", int'(status[3]), 0);
      step(0, 0, 1, 1, 1, 0, 0, 0, 0, 0);
      chk("R3 overrun in pass-through", int'(status[3]), 1);
      // R4: coincident read and overrun keeps flag, plain read clears
      step(1, 0, 16, 5, 1, 0, 0, 1, 0, 0);
      chk("R4 coincident keeps", int'(status[3]), 1);
      step(1, 0, 16, 5, 0, 0, 0, 1, 0, 0);
      chk("R4 read clears", int'(status[3]), 0);
      // R6: threshold edge in UART mode
      step(1, 0, 7, 5, 1, 0, 0, 0, 0, 0);
      chk("R6 below threshold", int'(irq), 0);
      step(1, 0, 8, 5, 0, 0, 0, 0, 0, 0);
      chk("R6 at threshold", int'(irq), 1);
      // R7: timeout with FIFO enabled in pass-through
      step(0, 1, 3, 5, 1, 0, 0, 0, 0, 0);
      idle(0, 1, 3, 5, TO - 1);
      chk("R7 not yet expired", int'(irq), 0);
      idle(0, 1, 3, 5, 2);
      chk("R7 expired", int'(irq), 1);
      step(0, 1, 2, 5, 0, 1, 0, 0, 0, 0);
      chk("R7 read drops", int'(irq), 0);
      // R9/R8: hysteresis with transmit enabled, receive masked
      step(1, 0, 0, 5, 0, 0, 0, 0, 1, 8'h02);
      step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R9 empty sets", int'(irq), 1);
      step(1, 0, 0, 1, 0, 0, 1, 0, 0, 0);
      chk("R9 level 1 holds", int'(irq), 1);
      step(1, 0, 0, 2, 0, 0, 1, 0, 0, 0);
      chk("R9 level 2 holds", int'(irq), 1);
      step(1, 0, 0, 3, 0, 0, 1, 0, 0, 0);
      chk("R9 level 3 releases", int'(irq), 0);
      step(1, 0, 0, 2, 0, 0, 0, 0, 0, 0);
      chk("R9 stays released", int'(irq), 0);
      step(0, 0, 0, 1, 0, 0, 1, 0, 0, 0);
      chk("R8 pass-through written", int'(irq), 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R8 pass-through empty", int'(irq), 1);
      step(0, 0, 1, 0, 0, 0, 0, 0, 1, 8'h08);
      chk("R10 swap enables", int'({rx_ie, tx_ie}), 2);
      step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
      chk("R5 unread byte", int'(irq), 1);

      // constrained random phases across modes
      for (int ph = 0; ph < 12; ph++) begin
         bit um = ph[0];
         bit fe = ph[1];
         rl = 0; tl = 0;
         for (int c = 0; c < 1500; c++) begin
            bit quiet = ($urandom % 64) < 40 && c % 200 > 100;
            if ($urandom % 10 == 0) begin
               int r = $urandom % 6;
               rl = (r == 0) ? 0 : (r == 1) ? DEPTH : (r == 2) ? THR : int'($urandom % (DEPTH + 1));
               if (!(um | fe) && rl > 1) rl = rl % 2;
               tl = ($urandom % 3 == 0) ? 0 : int'($urandom % 6);
            end
            step(um, fe, rl, tl,
                 !quiet && ($urandom % 8 == 0), !quiet && ($urandom % 8 == 0),
                 ($urandom % 8 == 0), ($urandom % 6 == 0),
                 ($urandom % 100 == 0), 8'($urandom));
         end
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule